// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is an on-chip synchronous static memory whose command and data phases are offset by a fixed pipeline. A command carries the address, the direction, the byte-write enables and the chip enables, and is sampled on a rising clock edge. The data for that command moves two valid clock edges later, in either direction. A write's data is sampled from `din` on that edge. A read's data is presented on `dout` right after it. Because reads and writes take the same path and keep the same spacing, a host can alternate directions on every cycle with no idle slot in between.

Beside single accesses, the block runs four-word bursts. A burst starts with a load command and continues with advance cycles. The two low address bits step through a linear or an interleaved order, and the direction and byte enables of the loading command stay in force for the whole burst. An active-low clock enable freezes the whole block. A combinational output enable masks the read-data valid flag, and the read data beside it. The data bus is split into `din`, `dout` and a `dout_en` flag that stands in for the driven or high-impedance state of a shared bus.

Top module: `zbt_sram`

## Requirements
- R1: A command sampled at a valid edge (`cke_n` low) has its data phase two valid edges later. A write samples `din` at that second edge. A read drives its word from just after that edge until the next valid edge. After only one valid edge, no data for the command is shown.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued one cycle after a write to the same address returns the newly written word.
- R3: During a cycle with `cke_n` high, all synchronous inputs are ignored and every register, including the output register, keeps its value. Such cycles do not count toward the latency in R1.
- R4: When `adv_ld` is low (load) and any chip enable is inactive (`ce1_n` high, `ce2_n` high or `ce2` low), the cycle is a deselect. It neither reads nor writes, and it ends any running burst.
- R5: When `adv_ld` is high (advance) during a running burst, the next burst address is used, and the direction and byte enables of the load that started the burst are kept, whatever `rw_n` and `bw_n` show. The fifth word of a burst wraps back to the loaded address.
- R6: With `lin_order` high, the two low address bits of burst word k are (loaded low bits + k) mod 4, and the upper bits stay fixed.
- R7: With `lin_order` low, the two low address bits of burst word k are the loaded low bits XOR k.
- R8: In a write, byte lane i (bits 9*i+8 down to 9*i) is stored only when `bw_n[i]` is low. Other lanes keep their old contents.
- R9: While `oe_n` is high, `dout_en` is low and `dout` is zero at once, without waiting for a clock edge.
- R10: `dout_en` is high only when the operation in the data phase is a read and `oe_n` is low. Otherwise `dout` is zero.
- R11: Synchronous reset (`rst` high at an edge) empties the pipeline, so no data phase follows. It leaves the memory contents unchanged.
- R12: An advance cycle with no running burst, for example after a deselect, starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| addr | input | ADDR_W | Word address for load commands |
| rw_n | input | 1 | 1 = read, 0 = write (taken at load) |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| bw_n | input | LANES | Byte-write enables, active low, one per 9-bit lane |
| lin_order | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| din | input | LANES*LANE_W | Write data, sampled at the write's data edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries valid read data |

## Verification
The bench works on the edges where latency and hazards meet. A read placed directly after a write to the same word would return stale data if the write were not forwarded. Stall cycles that were counted toward the latency would expose read data one cycle early. A stall that did not freeze the output register would drop or shift the data on screen. Bursts are checked in both orders, including the wrap on the fifth word, with `rw_n` and `bw_n` toggled during the advances. A design that followed the live pins would overwrite words, and one that used the wrong order would return a different lane. The bench also checks partial byte writes, each chip enable being inactive on its own, advances after a deselect, and reset in the middle of a read. A design that let any of these start an operation, or that cleared memory on reset, shows the wrong `dout` or a spurious `dout_en`.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int DEF_ADDR_W = 6;
  localparam int DEF_LANES  = 4;
  localparam int DEF_LANE_W = 9;
  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low address bits of burst word 'step' relative to the loaded bits
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] base,
    input logic [BURST_BITS-1:0] step,
    input logic                  linear
  );
    return linear ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANES  = DEF_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              sel,
  input  logic              rd,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  be_in,
  output op_e               op_nxt,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [LANES-1:0]  be_nxt
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic                  act_q;
  op_e                   op_q;
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic [BURST_BITS-1:0] cnt_inc;
  logic [LANES-1:0]      be_q;
  logic [HI_W-1:0]       base_hi;

  assign cnt_inc = cnt_q + 1'b1;
  assign base_hi = base_q[ADDR_W-1:BURST_BITS];

  always_comb begin
    op_nxt   = OP_NOP;
    addr_nxt = addr_in;
    be_nxt   = be_in;
    if (load) begin
      if (sel) op_nxt = rd ? OP_RD : OP_WR;
    end else if (act_q) begin
      op_nxt   = op_q;
      be_nxt   = be_q;
      addr_nxt = {base_hi, burst_low(base_q[BURST_BITS-1:0], cnt_inc, linear)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      op_q   <= OP_NOP;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else if (en) begin
      if (load) begin
        act_q  <= sel;
        op_q   <= rd ? OP_RD : OP_WR;
        base_q <= addr_in;
        cnt_q  <= '0;
        be_q   <= be_in;
      end else if (act_q) begin
        cnt_q  <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/zbt_lane.sv
module zbt_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              fwd,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[waddr] <= wdata;
      rdata <= fwd ? wdata : mem[raddr];
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw_n,
  input  logic              adv_ld,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              ce2,
  input  logic              cke_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              lin_order,
  input  logic [WORD_W-1:0] din,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic              en;
  logic              sel;
  op_e               op_c;
  logic [ADDR_W-1:0] addr_c;
  logic [LANES-1:0]  be_c;

  op_e               op1_q, op2_q;
  logic [ADDR_W-1:0] a1_q, a2_q;
  logic [LANES-1:0]  be1_q, be2_q;
  logic              rd3_q;
  logic [WORD_W-1:0] dout_q;
  logic [WORD_W-1:0] rd_word;
  logic              fwd;

  assign en  = ~cke_n;
  assign sel = ~ce1_n & ~ce2_n & ce2;

  zbt_burst_ctl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_burst (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (~adv_ld),
    .sel      (sel),
    .rd       (rw_n),
    .linear   (lin_order),
    .addr_in  (addr),
    .be_in    (~bw_n),
    .op_nxt   (op_c),
    .addr_nxt (addr_c),
    .be_nxt   (be_c)
  );

  // read in stage 1 meets the write of the older command in stage 2
  assign fwd = (op1_q == OP_RD) && (op2_q == OP_WR) && (a1_q == a2_q);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    zbt_lane #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk   (clk),
      .en    (en),
      .we    ((op2_q == OP_WR) && be2_q[i]),
      .waddr (a2_q),
      .wdata (din[i*LANE_W +: LANE_W]),
      .raddr (a1_q),
      .fwd   (fwd && be2_q[i]),
      .rdata (rd_word[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q  <= OP_NOP;
      op2_q  <= OP_NOP;
      rd3_q  <= 1'b0;
      dout_q <= '0;
    end else if (en) begin
      op1_q  <= op_c;
      op2_q  <= op1_q;
      rd3_q  <= (op2_q == OP_RD);
      dout_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a1_q  <= addr_c;
      be1_q <= be_c;
      a2_q  <= a1_q;
      be2_q <= be1_q;
    end
  end

  assign dout_en = rd3_q & ~oe_n;
  assign dout    = dout_en ? dout_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_n,
  input logic              adv_ld,
  input logic              rw_n,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              ce2,
  input logic              oe_n,
  input logic [WORD_W-1:0] dout,
  input logic              dout_en
);

  logic       sel;
  logic [2:0] sh_ld;
  logic [2:0] sh_any;

  assign sel = ~ce1_n & ~ce2_n & ce2;

  // port-level shadow of the three valid edges a read travels
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ld  <= '0;
      sh_any <= '0;
    end else if (!cke_n) begin
      sh_ld  <= {sh_ld[1:0], ~adv_ld & sel & rw_n};
      sh_any <= {sh_any[1:0], adv_ld | (sel & rw_n)};
    end
  end

  p_load_read_lat_r1: assert property (@(posedge clk) disable iff (rst)
    (sh_ld[2] && !oe_n) |-> dout_en);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> (($stable(dout_en) && $stable(dout)) || !$stable(oe_n)));

  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> sh_any[2]);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!dout_en && dout == '0));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

  p_reset_nop_r11: assert property (@(posedge clk)
    rst |=> !dout_en);

endmodule

bind zbt_sram zbt_sram_chk #(.WORD_W(WORD_W)) u_zbt_chk (
  .clk     (clk),
  .rst     (rst),
  .cke_n   (cke_n),
  .adv_ld  (adv_ld),
  .rw_n    (rw_n),
  .ce1_n   (ce1_n),
  .ce2_n   (ce2_n),
  .ce2     (ce2),
  .oe_n    (oe_n),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;

  localparam int AW = 6;
  localparam int W  = 36;
  localparam logic [2:0] CE_ON  = 3'b001;
  localparam logic [2:0] CE_OFF = 3'b100;
  localparam logic [W-1:0] GARB = 36'hF_DEAD_BEEF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rw_n = 1'b1, adv_ld = 1'b0;
  logic          ce1_n = 1'b1, ce2_n = 1'b0, ce2 = 1'b1;
  logic          cke_n = 1'b0;
  logic [3:0]    bw_n = 4'hF;
  logic          lin_order = 1'b1;
  logic [W-1:0]  din = '0;
  logic          oe_n = 1'b0;
  logic [W-1:0]  dout;
  logic          dout_en;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zbt_sram #(.ADDR_W(AW)) i_zbt_sram (
    .clk(clk), .rst(rst), .addr(addr), .rw_n(rw_n), .adv_ld(adv_ld),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .ce2(ce2), .cke_n(cke_n), .bw_n(bw_n),
    .lin_order(lin_order), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [W-1:0] pat(input int k);
    return {4'h9, 8'(k), 24'hA5_C300} ^ 36'(k * 37);
  endfunction

  task automatic cyc(input logic adv, input logic rd, input logic [2:0] ce,
                     input logic [3:0] bwn, input logic [AW-1:0] a,
                     input logic [W-1:0] d, input logic stall);
    adv_ld = adv; rw_n = rd; {ce1_n, ce2_n, ce2} = ce;
    bw_n = bwn; addr = a; din = d; cke_n = stall;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ld_rd(input logic [AW-1:0] a, input logic [W-1:0] d);
    cyc(1'b0, 1'b1, CE_ON, 4'hF, a, d, 1'b0);
  endtask
  task automatic ld_wr(input logic [AW-1:0] a, input logic [3:0] bwn, input logic [W-1:0] d);
    cyc(1'b0, 1'b0, CE_ON, bwn, a, d, 1'b0);
  endtask
  task automatic idle(input logic [W-1:0] d);
    cyc(1'b0, 1'b1, CE_OFF, 4'hF, '0, d, 1'b0);
  endtask
  task automatic adv(input logic rd, input logic [W-1:0] d);
    cyc(1'b1, rd, CE_ON, 4'h0, '0, d, 1'b0);
  endtask

  task automatic chk(input string tag, input logic exp_en, input logic [W-1:0] exp_d);
    logic [W-1:0] want;
    want = exp_en ? exp_d : '0;
    n_run++;
    if (dout_en !== exp_en || dout !== want) begin
      n_fail++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, dout_en, dout, exp_en, want);
    end
  endtask

  task automatic t_reset_state();
    chk("R11 reset state", 1'b0, '0);
  endtask

  task automatic t_latency();
    ld_wr(5, 4'h0, '0); idle('0); idle(36'h1_2345_6789);
    ld_rd(5, '0); idle('0);
    chk("R1 no data after one edge", 1'b0, '0);
    idle('0);
    chk("R1 read after two edges", 1'b1, 36'h1_2345_6789);
  endtask

  task automatic t_turnaround();
    ld_wr(10, 4'h0, '0);
    ld_rd(10, '0);
    ld_wr(11, 4'h0, 36'hA_AAA0_5555);
    ld_rd(11, '0);
    chk("R2 read right after write", 1'b1, 36'hA_AAA0_5555);
    ld_rd(10, 36'hB_0B0B_F0F0);
    chk("R10 write in data phase", 1'b0, '0);
    idle('0);
    chk("R2 forwarded second write", 1'b1, 36'hB_0B0B_F0F0);
    idle('0);
    chk("R2 back-to-back reads", 1'b1, 36'hA_AAA0_5555);
  endtask

  task automatic t_stall();
    ld_wr(20, 4'h0, '0); idle('0); idle(36'hC_3C3C_0001);
    ld_rd(20, '0);
    cyc(1'b0, 1'b0, CE_ON, 4'h0, 20, GARB, 1'b1);
    cyc(1'b0, 1'b0, CE_ON, 4'h0, 20, GARB, 1'b1);
    idle('0);
    chk("R3 stalls not counted", 1'b0, '0);
    idle('0);
    chk("R3 read after stalls", 1'b1, 36'hC_3C3C_0001);
    cyc(1'b0, 1'b0, CE_ON, 4'h0, 20, GARB, 1'b1);
    chk("R3 output held in stall", 1'b1, 36'hC_3C3C_0001);
    cyc(1'b1, 1'b0, CE_ON, 4'h0, 20, GARB, 1'b1);
    chk("R3 output held in second stall", 1'b1, 36'hC_3C3C_0001);
    idle(GARB); idle(GARB);
    ld_rd(20, '0); idle('0); idle('0);
    chk("R3 stalled write ignored", 1'b1, 36'hC_3C3C_0001);
  endtask

  task automatic t_deselect();
    logic [2:0] offs [3];
    offs[0] = 3'b101; offs[1] = 3'b011; offs[2] = 3'b000;
    ld_wr(30, 4'h0, '0); idle('0); idle(36'hE_1E1E_2222);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b1, offs[i], 4'hF, 30, '0, 1'b0);
      idle('0); idle('0);
      chk($sformatf("R4 deselect read ce=%b", offs[i]), 1'b0, '0);
    end
    cyc(1'b0, 1'b0, CE_OFF, 4'h0, 30, '0, 1'b0);
    idle('0); idle(GARB);
    ld_rd(30, '0); idle('0); idle('0);
    chk("R4 deselected write ignored", 1'b1, 36'hE_1E1E_2222);
  endtask

  task automatic t_burst_linear();
    lin_order = 1'b1;
    ld_wr(46, 4'h0, '0);
    adv(1'b0, '0); adv(1'b0, pat(0)); adv(1'b0, pat(1));
    idle(pat(2)); idle(pat(3));
    ld_rd(44, '0);
    adv(1'b0, GARB);
    adv(1'b0, GARB);
    chk("R6 linear word at 44", 1'b1, pat(2));
    adv(1'b0, GARB);
    chk("R6 linear word at 45", 1'b1, pat(3));
    adv(1'b0, GARB);
    chk("R5 burst keeps read at 46", 1'b1, pat(0));
    idle(GARB);
    chk("R6 linear word at 47", 1'b1, pat(1));
    idle(GARB);
    chk("R5 fifth word wraps to 44", 1'b1, pat(2));
  endtask

  task automatic t_burst_interleaved();
    lin_order = 1'b0;
    ld_wr(29, 4'h0, '0);
    adv(1'b0, '0); adv(1'b0, pat(4)); adv(1'b0, pat(5));
    idle(pat(6)); idle(pat(7));
    lin_order = 1'b1;
    ld_rd(28, '0); ld_rd(29, '0);
    ld_rd(30, '0);
    chk("R7 interleaved word at 28", 1'b1, pat(5));
    ld_rd(31, '0);
    chk("R7 interleaved word at 29", 1'b1, pat(4));
    idle('0);
    chk("R7 interleaved word at 30", 1'b1, pat(7));
    idle('0);
    chk("R7 interleaved word at 31", 1'b1, pat(6));
  endtask

  task automatic t_bytes();
    logic [W-1:0] m;
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    ld_wr(40, 4'h0, '0); idle('0); idle(36'hF_0F0F_0F0F);
    ld_wr(40, 4'b1010, '0); idle('0); idle(36'h3_5555_AAAA);
    ld_rd(40, '0); idle('0); idle('0);
    chk("R8 lanes 0 and 2 written", 1'b1,
        (36'hF_0F0F_0F0F & ~m) | (36'h3_5555_AAAA & m));
  endtask

  task automatic t_oe();
    logic [W-1:0] m;
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    ld_rd(40, '0); idle('0); idle('0);
    oe_n = 1'b1; #1;
    chk("R9 oe high masks at once", 1'b0, '0);
    oe_n = 1'b0; #1;
    chk("R9 oe low shows data", 1'b1,
        (36'hF_0F0F_0F0F & ~m) | (36'h3_5555_AAAA & m));
  endtask

  task automatic t_reset_mid();
    logic [W-1:0] m;
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    ld_rd(40, '0); idle('0);
    rst = 1'b1; idle('0); rst = 1'b0;
    chk("R11 reset drops pending read", 1'b0, '0);
    idle('0);
    chk("R11 pipeline stays empty", 1'b0, '0);
    ld_rd(40, '0); idle('0); idle('0);
    chk("R11 memory kept over reset", 1'b1,
        (36'hF_0F0F_0F0F & ~m) | (36'h3_5555_AAAA & m));
  endtask

  task automatic t_adv_after_deselect();
    lin_order = 1'b1;
    ld_wr(44, 4'h0, '0); idle('0); idle(pat(2));
    adv(1'b1, '0);
    adv(1'b0, GARB);
    adv(1'b0, GARB);
    chk("R12 advance read after deselect", 1'b0, '0);
    adv(1'b0, GARB);
    chk("R12 advance idle", 1'b0, '0);
    idle(GARB); idle(GARB);
    ld_rd(45, '0); ld_rd(46, '0);
    ld_rd(47, '0);
    chk("R12 word 45 untouched", 1'b1, pat(3));
    idle('0);
    chk("R12 word 46 untouched", 1'b1, pat(0));
    idle('0);
    chk("R12 word 47 untouched", 1'b1, pat(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle('0);
    t_reset_state();
    t_latency();
    t_turnaround();
    t_stall();
    t_deselect();
    t_burst_linear();
    t_burst_interleaved();
    t_bytes();
    t_oe();
    t_reset_mid();
    t_adv_after_deselect();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule